// File: doc/BRIEF.md
# Multi-cycle Accumulator Processor Controller

This block is the control sequencer for a small accumulator machine that has a 16-bit instruction word. It fetches each instruction over a memory interface paced by a single wait line, decodes the top two bits of the instruction register, and then runs one of four short execution sequences: load, store, add, or branch if the accumulator is negative. Every datapath action (clearing, incrementing or loading the program counter, loading the memory address, buffer, instruction and accumulator registers, and the memory request, read and write controls) comes out as a strobe. Each strobe is decoded from the current state alone.

The datapath registers and the memory sit outside the block. The controller sees only four conditions: the external reset, the memory wait line, the two opcode bits and the accumulator sign bit. Reset and wait each pass through a synchronizer flop before the next-state logic uses them, so the sequencer reacts to them one clock later than they change. The opcode bits and the sign bit already come from registers in the same clock domain and are used directly. The current state is also exposed, so that the sequence can be observed.

Top module: `acc_ctrl`

## Requirements
- R1: When the external reset is high at a clock edge, the state at the following edge becomes RES (code 0000). This holds from every state. While the controller is in RES, the only strobe asserted is the PC clear.
- R2: The state codes are RES=0000, IF0=0001, IF1=0010, IF2=0011, IF3=0100, OD=0101, LD0=0110, LD1=0111, LD2=1000, ST0=1001, ST1=1010, AD0=1011, AD1=1100, AD2=1101, BR0=1110 and BR1=1111. They appear on `state_o`. Once reset is low, RES always moves to IF0.
- R3: IF0 asserts both the copy of the PC into the MAR and the PC increment, and it always moves to IF1.
- R4: IF1 asserts no strobe. It stays in IF1 while the synchronized wait is 0 and moves to IF2 when it is 1. IF2 asserts the memory request, the memory read and the capture of memory data into the MBR. It stays in IF2 while the synchronized wait is 1 and moves to IF3 when it is 0.
- R5: IF3 asserts the IR load from the MBR. It stays in IF3 while the synchronized wait is 0 and moves to OD when it is 1.
- R6: OD asserts no strobe and branches on the opcode: 00 goes to LD0, 01 to ST0, 10 to AD0 and 11 to BR0. The opcode has no effect in any other state.
- R7: In the load sequence, LD0 loads the MAR from the IR address field. LD1 performs a memory read into the MBR and stays in LD1 while the synchronized wait is 1. LD2 loads the AC from the MBR and moves to IF0.
- R8: In the store sequence, ST0 loads the MAR from the IR and the MBR from the AC. ST1 asserts the memory request and the memory write, stays in ST1 while the synchronized wait is 1, and then moves to IF0. Memory read and memory write are never asserted together.
- R9: In the add sequence, AD0 loads the MAR from the IR. AD1 performs a memory read into the MBR and stays in AD1 while the synchronized wait is 1. AD2 asserts the accumulate strobe (AC gets AC plus MBR) and moves to IF0.
- R10: BR0 asserts no strobe. It moves to BR1 when the accumulator sign bit is 1 and to IF0 when it is 0. BR1 loads the PC from the IR and moves to IF0. The sign bit has no effect in any other state.
- R11: A change on the wait line becomes visible to the sequencer one clock after it is sampled. A wait-controlled transition therefore occurs at the second clock edge after the line changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_in | input | 1 | External reset, active high, synchronized inside |
| mem_wait | input | 1 | Memory wait/acknowledge line, synchronized inside |
| ir_op | input | 2 | Opcode bits from the instruction register (bits 15:14) |
| ac_sign | input | 1 | Accumulator sign bit (bit 15) |
| pc_clr | output | 1 | Clear the program counter |
| pc_inc | output | 1 | Increment the program counter |
| mar_from_pc | output | 1 | Load the MAR from the PC |
| mar_from_ir | output | 1 | Load the MAR from the IR address field (bits 13:0) |
| mbr_from_mem | output | 1 | Capture memory data into the MBR |
| mbr_from_ac | output | 1 | Load the MBR from the AC |
| ir_load | output | 1 | Load the IR from the MBR |
| ac_from_mbr | output | 1 | Load the AC from the MBR |
| ac_add | output | 1 | Load the AC with AC plus MBR |
| pc_from_ir | output | 1 | Load the PC from the IR address field |
| mem_req | output | 1 | Memory request |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| state_o | output | 4 | Current state code |

## Verification
Strobes are decoded from the state register, so each one changes right after the edge at which the state changes. A change on the opcode or the sign bit takes effect at the next edge. A change on the wait line or the reset takes effect at the second edge, because of the synchronizer flop. The bench drives every input on the falling clock edge and samples on the falling edge after the required number of rising edges. At each wait-driven step it first confirms that the state has not yet moved at the first edge, and then confirms the transition at the second edge. Each scenario task starts from a known state, and every check covers both the state code and the full strobe vector.

// File: rtl/acc_ctrl_pkg.sv
package acc_ctrl_pkg;

  localparam int STATE_W = 4;
  localparam int OP_W    = 2;

  typedef enum logic [STATE_W-1:0] {
    S_RES = 4'd0,
    S_IF0 = 4'd1,
    S_IF1 = 4'd2,
    S_IF2 = 4'd3,
    S_IF3 = 4'd4,
    S_OD  = 4'd5,
    S_LD0 = 4'd6,
    S_LD1 = 4'd7,
    S_LD2 = 4'd8,
    S_ST0 = 4'd9,
    S_ST1 = 4'd10,
    S_AD0 = 4'd11,
    S_AD1 = 4'd12,
    S_AD2 = 4'd13,
    S_BR0 = 4'd14,
    S_BR1 = 4'd15
  } ctl_state_e;

  localparam logic [OP_W-1:0] OP_LOAD  = 2'b00;
  localparam logic [OP_W-1:0] OP_STORE = 2'b01;
  localparam logic [OP_W-1:0] OP_ADD   = 2'b10;
  localparam logic [OP_W-1:0] OP_BRNEG = 2'b11;

  typedef struct packed {
    logic pc_clr;
    logic pc_inc;
    logic mar_from_pc;
    logic mar_from_ir;
    logic mbr_from_mem;
    logic mbr_from_ac;
    logic ir_load;
    logic ac_from_mbr;
    logic ac_add;
    logic pc_from_ir;
    logic mem_req;
    logic mem_rd;
    logic mem_wr;
  } ctl_strobe_t;

  localparam ctl_strobe_t STROBE_IDLE = '0;

endpackage

// File: rtl/acc_ctrl_sync.sv
module acc_ctrl_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    chain_q[0] <= d_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      chain_q[g] <= chain_q[g-1];
    end
  end

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/acc_ctrl_next.sv
module acc_ctrl_next
  import acc_ctrl_pkg::*;
(
  input  ctl_state_e      cur,
  input  logic            rst_s,
  input  logic            wait_s,
  input  logic [OP_W-1:0] ir_op,
  input  logic            ac_sign,
  output ctl_state_e      nxt
);

  ctl_state_e op_target;

  always_comb begin
    case (ir_op)
      OP_LOAD:  op_target = S_LD0;
      OP_STORE: op_target = S_ST0;
      OP_ADD:   op_target = S_AD0;
      default:  op_target = S_BR0;
    endcase
  end

  always_comb begin
    nxt = cur;
    if (rst_s) begin
      nxt = S_RES;
    end else begin
      case (cur)
        S_RES: nxt = S_IF0;
        S_IF0: nxt = S_IF1;
        S_IF1: nxt = wait_s ? S_IF2 : S_IF1;
        S_IF2: nxt = wait_s ? S_IF2 : S_IF3;
        S_IF3: nxt = wait_s ? S_OD  : S_IF3;
        S_OD:  nxt = op_target;
        S_LD0: nxt = S_LD1;
        S_LD1: nxt = wait_s ? S_LD1 : S_LD2;
        S_LD2: nxt = S_IF0;
        S_ST0: nxt = S_ST1;
        S_ST1: nxt = wait_s ? S_ST1 : S_IF0;
        S_AD0: nxt = S_AD1;
        S_AD1: nxt = wait_s ? S_AD1 : S_AD2;
        S_AD2: nxt = S_IF0;
        S_BR0: nxt = ac_sign ? S_BR1 : S_IF0;
        S_BR1: nxt = S_IF0;
        default: nxt = S_RES;
      endcase
    end
  end

endmodule

// File: rtl/acc_ctrl_decode.sv
module acc_ctrl_decode
  import acc_ctrl_pkg::*;
(
  input  ctl_state_e  cur,
  output ctl_strobe_t strobe
);

  always_comb begin
    strobe = STROBE_IDLE;
    case (cur)
      S_RES: strobe.pc_clr = 1'b1;
      S_IF0: begin
        strobe.mar_from_pc = 1'b1;
        strobe.pc_inc      = 1'b1;
      end
      S_IF2, S_LD1, S_AD1: begin
        strobe.mem_req      = 1'b1;
        strobe.mem_rd       = 1'b1;
        strobe.mbr_from_mem = 1'b1;
      end
      S_IF3: strobe.ir_load = 1'b1;
      S_LD0, S_AD0: strobe.mar_from_ir = 1'b1;
      S_LD2: strobe.ac_from_mbr = 1'b1;
      S_ST0: begin
        strobe.mar_from_ir = 1'b1;
        strobe.mbr_from_ac = 1'b1;
      end
      S_ST1: begin
        strobe.mem_req = 1'b1;
        strobe.mem_wr  = 1'b1;
      end
      S_AD2: strobe.ac_add     = 1'b1;
      S_BR1: strobe.pc_from_ir = 1'b1;
      default: strobe = STROBE_IDLE;
    endcase
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic               clk,
  input  logic               rst_in,
  input  logic               mem_wait,
  input  logic [OP_W-1:0]    ir_op,
  input  logic               ac_sign,
  output logic               pc_clr,
  output logic               pc_inc,
  output logic               mar_from_pc,
  output logic               mar_from_ir,
  output logic               mbr_from_mem,
  output logic               mbr_from_ac,
  output logic               ir_load,
  output logic               ac_from_mbr,
  output logic               ac_add,
  output logic               pc_from_ir,
  output logic               mem_req,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [STATE_W-1:0] state_o
);

  logic        rst_s;
  logic        wait_s;
  logic [1:0]  sync_out;
  ctl_state_e  state_q;
  ctl_state_e  state_d;
  ctl_strobe_t strobe;

  acc_ctrl_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .d_in  ({rst_in, mem_wait}),
    .d_out (sync_out)
  );

  assign rst_s  = sync_out[1];
  assign wait_s = sync_out[0];

  acc_ctrl_next u_next (
    .cur     (state_q),
    .rst_s   (rst_s),
    .wait_s  (wait_s),
    .ir_op   (ir_op),
    .ac_sign (ac_sign),
    .nxt     (state_d)
  );

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end

  acc_ctrl_decode u_dec (
    .cur    (state_q),
    .strobe (strobe)
  );

  assign pc_clr       = strobe.pc_clr;
  assign pc_inc       = strobe.pc_inc;
  assign mar_from_pc  = strobe.mar_from_pc;
  assign mar_from_ir  = strobe.mar_from_ir;
  assign mbr_from_mem = strobe.mbr_from_mem;
  assign mbr_from_ac  = strobe.mbr_from_ac;
  assign ir_load      = strobe.ir_load;
  assign ac_from_mbr  = strobe.ac_from_mbr;
  assign ac_add       = strobe.ac_add;
  assign pc_from_ir   = strobe.pc_from_ir;
  assign mem_req      = strobe.mem_req;
  assign mem_rd       = strobe.mem_rd;
  assign mem_wr       = strobe.mem_wr;
  assign state_o      = state_q;

endmodule

// File: rtl/acc_ctrl_chk.sv
module acc_ctrl_chk (
  input logic       clk,
  input logic       rst_in,
  input logic       rst_s,
  input logic       wait_s,
  input logic [1:0] ir_op,
  input logic       ac_sign,
  input logic [3:0] state_o,
  input logic       pc_clr,
  input logic       mar_from_pc,
  input logic       mar_from_ir,
  input logic       mem_req,
  input logic       mem_rd,
  input logic       mem_wr
);

  AST_RESET_FORCE: assert property (@(posedge clk) rst_s |=> state_o == 4'd0); // R1

  AST_RES_CLEARS_PC: assert property (@(posedge clk) disable iff (rst_in || rst_s)
    state_o == 4'd0 |-> pc_clr); // R1

  AST_RES_TO_IF0: assert property (@(posedge clk) disable iff (rst_in || rst_s)
    state_o == 4'd0 |=> state_o == 4'd1); // R2

  AST_IF1_WAITS: assert property (@(posedge clk) disable iff (rst_in || rst_s)
    (state_o == 4'd2 && !wait_s) |=> state_o == 4'd2); // R4

  AST_OD_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst_in || rst_s)
    state_o == 4'd5 |=> (state_o == 4'd6 || state_o == 4'd9 ||
                         state_o == 4'd11 || state_o == 4'd14)); // R6

  AST_OD_BRNEG_OP: assert property (@(posedge clk) disable iff (rst_in || rst_s)
    (state_o == 4'd5 && ir_op == 2'b11) |=> state_o == 4'd14); // R6

  AST_BR_TAKEN: assert property (@(posedge clk) disable iff (rst_in || rst_s)
    (state_o == 4'd14 && ac_sign) |=> state_o == 4'd15); // R10

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst_in || rst_s)
    !(mem_rd && mem_wr)); // R8

  AST_REQ_WITH_DIR: assert property (@(posedge clk) disable iff (rst_in || rst_s)
    mem_req |-> $onehot0({mem_rd, mem_wr}) && (mem_rd || mem_wr)); // R8

  AST_MAR_SOURCE: assert property (@(posedge clk) disable iff (rst_in || rst_s)
    $onehot0({mar_from_pc, mar_from_ir})); // R7

endmodule

bind acc_ctrl acc_ctrl_chk u_chk (
  .clk         (clk),
  .rst_in      (rst_in),
  .rst_s       (rst_s),
  .wait_s      (wait_s),
  .ir_op       (ir_op),
  .ac_sign     (ac_sign),
  .state_o     (state_o),
  .pc_clr      (pc_clr),
  .mar_from_pc (mar_from_pc),
  .mar_from_ir (mar_from_ir),
  .mem_req     (mem_req),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr)
);

// File: tb/tb_acc_ctrl.sv
module tb_acc_ctrl;

  localparam time CLK_PERIOD = 10ns;

  // strobe vector order: pc_clr pc_inc mar_from_pc mar_from_ir mbr_from_mem
  // mbr_from_ac ir_load ac_from_mbr ac_add pc_from_ir mem_req mem_rd mem_wr
  localparam logic [12:0] V_NONE  = 13'h0000;
  localparam logic [12:0] V_RES   = 13'h1000;
  localparam logic [12:0] V_IF0   = 13'h0C00;
  localparam logic [12:0] V_RDMEM = 13'h0106;
  localparam logic [12:0] V_IRLD  = 13'h0040;
  localparam logic [12:0] V_MARIR = 13'h0200;
  localparam logic [12:0] V_LD2   = 13'h0020;
  localparam logic [12:0] V_ST0   = 13'h0280;
  localparam logic [12:0] V_ST1   = 13'h0005;
  localparam logic [12:0] V_AD2   = 13'h0010;
  localparam logic [12:0] V_BR1   = 13'h0008;

  logic clk = 1'b0;
  logic rst_in = 1'b1;
  logic mem_wait = 1'b0;
  logic [1:0] ir_op = 2'b00;
  logic ac_sign = 1'b0;
  logic pc_clr, pc_inc, mar_from_pc, mar_from_ir, mbr_from_mem, mbr_from_ac;
  logic ir_load, ac_from_mbr, ac_add, pc_from_ir, mem_req, mem_rd, mem_wr;
  logic [3:0] state_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_ctrl dut (
    .clk(clk), .rst_in(rst_in), .mem_wait(mem_wait), .ir_op(ir_op), .ac_sign(ac_sign),
    .pc_clr(pc_clr), .pc_inc(pc_inc), .mar_from_pc(mar_from_pc), .mar_from_ir(mar_from_ir),
    .mbr_from_mem(mbr_from_mem), .mbr_from_ac(mbr_from_ac), .ir_load(ir_load),
    .ac_from_mbr(ac_from_mbr), .ac_add(ac_add), .pc_from_ir(pc_from_ir),
    .mem_req(mem_req), .mem_rd(mem_rd), .mem_wr(mem_wr), .state_o(state_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(input logic [3:0] st, input logic [12:0] vec, input string req);
    logic [12:0] act;
    act = {pc_clr, pc_inc, mar_from_pc, mar_from_ir, mbr_from_mem, mbr_from_ac,
           ir_load, ac_from_mbr, ac_add, pc_from_ir, mem_req, mem_rd, mem_wr};
    checks++;
    if (state_o !== st || act !== vec) begin
      errors++;
      $display("FAIL %s: state=%b strobes=%h expected state=%b strobes=%h",
               req, state_o, act, st, vec);
    end
  endtask

  task automatic test_reset();
    rst_in = 1'b1; mem_wait = 1'b0;
    step(3);
    expect_st(4'b0000, V_RES, "R1 reset state");
    rst_in = 1'b0;
    step(1);
    expect_st(4'b0000, V_RES, "R1 reset release seen one cycle late");
    step(1);
    expect_st(4'b0001, V_IF0, "R2 RES to IF0");
  endtask

  // entered with state IF0; leaves with state OD and mem_wait high
  task automatic run_fetch(input logic [1:0] op);
    mem_wait = 1'b0;
    ir_op = ~op;
    ac_sign = 1'b1;
    expect_st(4'b0001, V_IF0, "R3 IF0 strobes");
    step(1);
    expect_st(4'b0010, V_NONE, "R3 IF0 to IF1");
    step(3);
    expect_st(4'b0010, V_NONE, "R4 IF1 holds while wait low");
    mem_wait = 1'b1;
    step(1);
    expect_st(4'b0010, V_NONE, "R11 IF1 wait rise not yet seen");
    step(1);
    expect_st(4'b0011, V_RDMEM, "R4 IF2 read strobes");
    ir_op = op;
    step(2);
    expect_st(4'b0011, V_RDMEM, "R4 IF2 holds while wait high");
    mem_wait = 1'b0;
    step(1);
    expect_st(4'b0011, V_RDMEM, "R11 IF2 wait fall not yet seen");
    step(1);
    expect_st(4'b0100, V_IRLD, "R5 IF3 IR load");
    step(1);
    expect_st(4'b0100, V_IRLD, "R5 IF3 holds while wait low");
    mem_wait = 1'b1;
    step(2);
    expect_st(4'b0101, V_NONE, "R5 IF3 to OD");
  endtask

  task automatic test_load();
    run_fetch(2'b00);
    step(1);
    expect_st(4'b0110, V_MARIR, "R6 R7 opcode 00 to LD0");
    step(1);
    expect_st(4'b0111, V_RDMEM, "R7 LD1 read");
    step(2);
    expect_st(4'b0111, V_RDMEM, "R7 LD1 holds while wait high");
    mem_wait = 1'b0;
    step(1);
    expect_st(4'b0111, V_RDMEM, "R11 LD1 wait fall not yet seen");
    step(1);
    expect_st(4'b1000, V_LD2, "R7 LD2 AC from MBR");
    step(1);
    expect_st(4'b0001, V_IF0, "R7 LD2 to IF0");
  endtask

  task automatic test_store();
    run_fetch(2'b01);
    step(1);
    expect_st(4'b1001, V_ST0, "R6 R8 opcode 01 to ST0");
    step(1);
    expect_st(4'b1010, V_ST1, "R8 ST1 write");
    step(1);
    expect_st(4'b1010, V_ST1, "R8 ST1 holds while wait high");
    mem_wait = 1'b0;
    step(2);
    expect_st(4'b0001, V_IF0, "R8 ST1 to IF0");
  endtask

  task automatic test_add();
    run_fetch(2'b10);
    step(1);
    expect_st(4'b1011, V_MARIR, "R6 R9 opcode 10 to AD0");
    step(1);
    expect_st(4'b1100, V_RDMEM, "R9 AD1 read");
    mem_wait = 1'b0;
    step(2);
    expect_st(4'b1101, V_AD2, "R9 AD2 accumulate");
    step(1);
    expect_st(4'b0001, V_IF0, "R9 AD2 to IF0");
  endtask

  task automatic test_branch(input logic neg);
    run_fetch(2'b11);
    ac_sign = neg;
    step(1);
    expect_st(4'b1110, V_NONE, "R6 R10 opcode 11 to BR0");
    mem_wait = 1'b0;
    step(1);
    if (neg) begin
      expect_st(4'b1111, V_BR1, "R10 sign set goes to BR1");
      step(1);
    end
    expect_st(4'b0001, V_IF0, "R10 branch returns to IF0");
  endtask

  task automatic test_mid_reset();
    mem_wait = 1'b0;
    step(2);
    mem_wait = 1'b1;
    step(2);
    expect_st(4'b0011, V_RDMEM, "R4 in IF2 before reset");
    rst_in = 1'b1;
    step(1);
    expect_st(4'b0011, V_RDMEM, "R1 reset not yet seen");
    step(1);
    expect_st(4'b0000, V_RES, "R1 reset forces RES from IF2");
    rst_in = 1'b0;
    mem_wait = 1'b0;
    step(2);
    expect_st(4'b0001, V_IF0, "R2 leaves RES after reset");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(1);
    test_reset();
    test_load();
    test_store();
    test_add();
    test_branch(1'b1);
    test_branch(1'b0);
    test_mid_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule